// File: doc/BRIEF.md
# Timer Wrap Interrupt Status Register

This block holds the wrap status of three timer channels and produces their interrupt requests. Each channel has a counter that advances by one on every count-enable pulse. Channels 0 and 1 only count up. Channel 2 counts up or down, as a direction input selects. When a counter passes through its wrap point, the block sets that channel's status flag. The flag then drives an interrupt request if software has enabled that channel.

Software sees one 8-bit register through a plain single-cycle bus. Enable bits are ordinary storage. A status flag cannot be set from the bus, and it is cleared only by a two-step handshake. First a read must return the flag as 1, which arms a per-bit latch. Then a write of 0 to that bit clears the flag and uses up the latch. This stops a late event from being lost by a write that software issued blindly. Read data is combinational and always valid. Every pin is plain control or status, so there is no valid/ready handshake and no back-pressure.

Top module: `ovf_status_reg`

## Requirements
- R1: After reset the register reads 8'h88 and all three interrupt outputs are 0.
- R2: Bits 7 and 3 always read 1, and writes to them have no effect.
- R3: Bits 6, 5 and 4 are the enables for channels 2, 1 and 0. Each reads back exactly the value last written and changes only on a write.
- R4: Status bits 0 and 1 hold the flags of channels 0 and 1. A flag becomes 1 one clock after the count pulse that takes its counter from all ones (16'hFFFF) to zero, and stays 0 on every earlier count.
- R5: Status bit 2 is set by channel 2 in both directions. Counting up, the wrap is 16'hFFFF to 16'h0000. Counting down (ch2_down=1), the wrap is 16'h0000 to 16'hFFFF.
- R6: A flag clears only when a 0 is written to its bit after a read that returned that bit as 1. A 0-write with no such read leaves the flag at 1.
- R7: Writing 1 to a status bit never sets it, and never changes a flag that is already 1.
- R8: irq[i] is 1 exactly when flag i and enable i are both 1.
- R9: If a set event and an armed clearing write fall in the same cycle, the flag stays 1. That write still uses up the arming read.
- R10: Arming is per bit and is used once. A clearing write needs a fresh read that returned that bit as 1, and a read taken while a flag was 0 does not arm it.
- R11: A read does not change any readable bit or any interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Bus read strobe; arms the latch of every flag that reads 1 |
| wr_en | input | 1 | Bus write strobe |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Register contents, combinational |
| cnt_en | input | 3 | Per-channel count pulse, one step per cycle held high |
| ch2_down | input | 1 | Channel 2 direction: 1 counts down, 0 counts up |
| irq | output | 3 | Per-channel interrupt request |

## Verification
The bench looks for a flag that clears after a blind 0-write, or after a second write that reuses an old read. It checks that a read taken while a flag was 0 does not arm that flag, and that a set event in the same cycle as a clearing write still leaves the flag at 1. A design that gets any of these wrong shows a status bit of 0 where the bench expects 1. The bench drives channel 2 through both of its wrap points, so a design that ignores underflow, or that flags at 16'hFFFE, sets the flag in the wrong cycle. A write of 1 that sets a flag, or a reserved bit that stores written data, shows up as a read-back mismatch.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  localparam int NCH    = 3;
  localparam int REG_W  = 8;
  localparam int CNT_W  = 16;
  localparam int FLG_LO = 0;      // status bits [2:0]
  localparam int ENB_LO = 4;      // enable bits [6:4]
  localparam int RSV_LO = 3;
  localparam int RSV_HI = 7;
endpackage

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int W      = 16,
  parameter bit UPDOWN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic dn,
  output logic wrap
);
  logic [W-1:0] cnt_q;
  logic         dir;

  generate
    if (UPDOWN) begin : g_bidir
      assign dir = dn;
    end else begin : g_uponly
      logic unused_dn;
      assign unused_dn = dn;
      assign dir = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (step)    cnt_q <= dir ? cnt_q - 1'b1 : cnt_q + 1'b1;
  end

  assign wrap = step && (dir ? (cnt_q == '0) : (&cnt_q));

  // R4/R5: a wrap event lands the counter on zero or on all ones
  p_wrap_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0 || (&cnt_q)));
endmodule

// File: rtl/flag_cell.sv
module flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_strobe,
  input  logic clr_req,
  output logic flag
);
  logic arm_q;
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 arm_q <= 1'b0;
    else if (clr_req && arm_q)  arm_q <= 1'b0;
    else if (rd_strobe && flag_q) arm_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_q <= 1'b0;
    else if (set_evt)           flag_q <= 1'b1;
    else if (clr_req && arm_q)  flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R6: an unarmed flag never drops
  p_no_blind_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q) |=> flag_q);
  // R9: a set event always leaves the flag high
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  // R10: arming needs a read that saw the flag
  p_arm_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm_q) |-> $past(rd_strobe && flag_q));
endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg
  import ovf_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic [NCH-1:0]   cnt_en,
  input  logic             ch2_down,
  output logic [NCH-1:0]   irq
);
  logic [NCH-1:0] wrap_evt;
  logic [NCH-1:0] flags;
  logic [NCH-1:0] en_q;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      wrap_counter #(.W(CW), .UPDOWN(i == NCH-1)) u_cnt (
        .clk(clk), .rst_n(rst_n), .step(cnt_en[i]), .dn(ch2_down),
        .wrap(wrap_evt[i])
      );
      flag_cell u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(wrap_evt[i]), .rd_strobe(rd_en),
        .clr_req(wr_en && !wdata[FLG_LO+i]), .flag(flags[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_en)  en_q <= wdata[ENB_LO +: NCH];
  end

  always_comb begin
    rdata                 = '0;
    rdata[RSV_HI]         = 1'b1;
    rdata[RSV_LO]         = 1'b1;
    rdata[ENB_LO +: NCH]  = en_q;
    rdata[FLG_LO +: NCH]  = flags;
  end

  assign irq = flags & en_q;

  // R3: enables move only on a bus write
  p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
  // R7: no flag rises without a counter wrap
  p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] == 1'b0) |=> (flags[0] == 1'b0 || $past(wrap_evt[0])));
endmodule

// File: tb/ovf_status_reg_tb.sv
module ovf_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0, ch2_down = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] cnt_en = '0;
  logic [2:0] irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  ovf_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .cnt_en(cnt_en), .ch2_down(ch2_down), .irq(irq)
  );

  // {write data, expected read-back} with all flags 0
  localparam logic [15:0] VEC [6] = '{
    16'hFF_F8, 16'h00_88, 16'h50_D8, 16'h27_A8, 16'h08_88, 16'h00_88
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [7:0] d,
                     input logic [2:0] ce, input logic dn);
    @(negedge clk);
    rd_en = r; wr_en = w; wdata = d; cnt_en = ce; ch2_down = dn;
    @(negedge clk);
    rd_en = 0; wr_en = 0; cnt_en = '0;
  endtask

  initial begin
    int cyc_cnt = 0;
    while (!done && cyc_cnt < 150000) begin @(posedge clk); cyc_cnt++; end
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    repeat (3) @(negedge clk);
    chk("R1 reset value", rdata, 8'h88);
    chk("R1 irq at reset", {5'd0, irq}, 8'h00);
    rst_n = 1'b1;

    for (int k = 0; k < 6; k++) begin
      cyc(0, 1, VEC[k][15:8], 3'b000, 0);
      chk("R2 R3 write/readback", rdata, VEC[k][7:0]);
    end

    // bring all counters to 16'hFFFF
    @(negedge clk); cnt_en = 3'b111;
    repeat (65535) @(negedge clk);
    cnt_en = 3'b000;
    chk("R4 no flag before wrap", rdata, 8'h88);
    cyc(0, 0, 8'h00, 3'b111, 0);
    chk("R4 R5 up wrap sets flags", rdata, 8'h8F);

    cyc(0, 1, 8'h00, 3'b000, 0);
    chk("R6 blind 0-write ignored", rdata, 8'h8F);
    cyc(0, 1, 8'h70, 3'b000, 0);
    chk("R3 enables set", rdata, 8'hFF);
    chk("R8 irq all", {5'd0, irq}, 8'h07);

    snap = rdata;
    cyc(1, 0, 8'h00, 3'b000, 0);
    chk("R11 read leaves value", rdata, snap);
    chk("R11 read leaves irq", {5'd0, irq}, 8'h07);
    cyc(0, 1, 8'h7E, 3'b000, 0);
    chk("R6 armed clear of flag0", rdata, 8'hFE);
    chk("R8 irq after clear", {5'd0, irq}, 8'h06);
    cyc(0, 1, 8'h7F, 3'b000, 0);
    chk("R7 write 1 does not set", rdata, 8'hFE);
    cyc(0, 1, 8'h79, 3'b000, 0);
    chk("R6 clear flags 1 and 2", rdata, 8'hF8);
    chk("R8 irq none", {5'd0, irq}, 8'h00);

    // channel 2 underflow 0 -> FFFF
    cyc(0, 0, 8'h00, 3'b100, 1);
    chk("R5 underflow sets flag2", rdata, 8'hFC);
    chk("R8 irq2", {5'd0, irq}, 8'h04);
    cyc(0, 1, 8'h70, 3'b000, 0);
    chk("R10 used arm not reused", rdata, 8'hFC);
    cyc(1, 0, 8'h00, 3'b000, 0);
    cyc(0, 1, 8'h70, 3'b000, 0);
    chk("R6 rearmed clear flag2", rdata, 8'hF8);

    // channel 2 up wrap FFFF -> 0
    cyc(0, 0, 8'h00, 3'b100, 0);
    chk("R5 up wrap sets flag2", rdata, 8'hFC);
    cyc(1, 0, 8'h00, 3'b000, 0);
    // armed clear coincides with underflow 0 -> FFFF
    cyc(0, 1, 8'h70, 3'b100, 1);
    chk("R9 set wins over clear", rdata, 8'hFC);
    cyc(0, 1, 8'h70, 3'b000, 0);
    chk("R9 arm consumed by losing write", rdata, 8'hFC);
    cyc(1, 0, 8'h00, 3'b000, 0);
    cyc(0, 1, 8'h70, 3'b000, 0);
    chk("R6 clear after fresh read", rdata, 8'hF8);

    // read while flag2 is 0, then flag2 sets (counter FFFF -> 0)
    cyc(1, 0, 8'h00, 3'b000, 0);
    cyc(0, 0, 8'h00, 3'b100, 0);
    cyc(0, 1, 8'h70, 3'b000, 0);
    chk("R10 read at 0 does not arm", rdata, 8'hFC);
    cyc(0, 1, 8'hF7, 3'b000, 0);
    chk("R2 R3 R7 mixed write", rdata, 8'hFC);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule